// File: doc/BRIEF.md
# Primary Interrupt Aggregator

This block is the first stage of a two-level interrupt tree. Up to eight secondary interrupt modules each raise one request per host interrupt line. The aggregator gathers these requests into one status byte per host line and drives one active-low interrupt output per line. Bit position in a status byte equals the index of the module slot. There is no mask at this stage: any request from a populated slot shows in its line's status and pulls that line's output low. The two lines work independently.

A small synchronous register port lets the host read both status bytes. The same port reaches a test-force register. Bits set in that register inject requests into both lines, so the interrupt path can be exercised without any secondary module taking part. Slots named unpopulated by a parameter (slots 6 and 7 by default) always read as zero and never assert an output.

Top module: `irq_primary_agg`

## Requirements
- R1: Status bit n of a line is 1 exactly one clock after the cycle in which module slot n's request for that line (or force bit n) was 1. Status bits are not sticky: a bit drops one clock after its request and force bit are both 0.
- R2: irq_n[l] is low (asserted) one clock after any request or force bit of a populated slot on line l is 1, and high otherwise. Line 0 and line 1 do not affect each other.
- R3: A read at offset 0x01 returns the line 0 status byte, and a read at offset 0x02 returns the line 1 status byte.
- R4: A write to offset 0x03 loads the force register, which applies to both lines. A read at 0x03 returns its contents. A later write of 0x00 removes the forced bits.
- R5: Slots whose bit is 0 in POP_MASK (default 8'h3F, so slots 6 and 7 are unpopulated) read as 0 in both status bytes and in the force register, and never assert either irq_n.
- R6: A read at any offset other than 0x01, 0x02 or 0x03 returns 0x00. A write to offset 0x01 or 0x02 has no effect on status or on irq_n.
- R7: After reset, both status bytes and the force register are 0, irq_n is 2'b11 and reg_rdata is 0x00.
- R8: reg_rdata is registered. It shows the addressed value one clock after the cycle in which reg_rd is high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Register offset |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Registered read data |
| req_in | input | 2*NUM_SLOTS (16) | Module requests; bits [7:0] go to line 0, bits [15:8] go to line 1 |
| irq_n | output | 2 | Active-low interrupt per host line; bit 0 is line 0 |

## Verification
A wrong status bit shows up in two places. The affected line's irq_n level is wrong one clock after the request changes, and reg_rdata is wrong one clock after a read of that line's offset. A force register that holds the wrong value corrupts both lines at once, so comparing the two status bytes against each other separates a force fault from a per-line fault. A fault in the populated-slot filtering appears as nonzero bits 6 and 7 on reads, or as a low irq_n when only unpopulated slots are active. Each of these shows up within two clocks of the stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned OFS_LINE0_STAT = 1;
   localparam int unsigned OFS_LINE1_STAT = 2;
   localparam int unsigned OFS_FORCE      = 3;
   localparam int unsigned NUM_LINES      = 2;
endpackage

// File: rtl/agg_force_reg.sv
module agg_force_reg #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [NUM_SLOTS-1:0] POP_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_SLOTS-1:0] force_q
);
   import irq_agg_pkg::*;

   logic hit;
   assign hit = wr && (addr == ADDR_W'(OFS_FORCE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   force_q <= '0;
      else if (hit) force_q <= wdata[NUM_SLOTS-1:0] & POP_MASK;
   end
endmodule

// File: rtl/agg_line_status.sv
module agg_line_status #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter logic [NUM_SLOTS-1:0] POP_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req,
   input  logic [NUM_SLOTS-1:0] force_bits,
   output logic [NUM_SLOTS-1:0] status_q,
   output logic                 line_n
);
   logic [NUM_SLOTS-1:0] status_d;
   assign status_d = (req | force_bits) & POP_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         line_n   <= 1'b1;
      end else begin
         status_q <= status_d;
         line_n   <= ~(|status_d);
      end
   end
endmodule

// File: rtl/agg_read_port.sv
module agg_read_port #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NUM_SLOTS-1:0]   stat0,
   input  logic [NUM_SLOTS-1:0]   stat1,
   input  logic [NUM_SLOTS-1:0]   force_bits,
   output logic [DATA_W-1:0]      rdata
);
   import irq_agg_pkg::*;

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == ADDR_W'(OFS_LINE0_STAT))      sel = DATA_W'(stat0);
      else if (addr == ADDR_W'(OFS_LINE1_STAT)) sel = DATA_W'(stat1);
      else if (addr == ADDR_W'(OFS_FORCE))      sel = DATA_W'(force_bits);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= sel;
   end
endmodule

// File: rtl/irq_primary_agg.sv
module irq_primary_agg #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [NUM_SLOTS-1:0] POP_MASK = 8'h3F
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   reg_wr,
   input  logic                                   reg_rd,
   input  logic [ADDR_W-1:0]                      reg_addr,
   input  logic [DATA_W-1:0]                      reg_wdata,
   output logic [DATA_W-1:0]                      reg_rdata,
   input  logic [irq_agg_pkg::NUM_LINES*NUM_SLOTS-1:0] req_in,
   output logic [irq_agg_pkg::NUM_LINES-1:0]      irq_n
);
   import irq_agg_pkg::*;

   localparam int unsigned LINES = NUM_LINES;

   if (NUM_SLOTS > DATA_W) begin : g_chk_width
      $error("NUM_SLOTS must not exceed DATA_W");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("ADDR_W too small for the register offsets");
   end

   logic [NUM_SLOTS-1:0] force_bits;
   logic [NUM_SLOTS-1:0] stat [LINES];

   agg_force_reg #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POP_MASK(POP_MASK)
   ) u_force (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .force_q(force_bits)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_line
      agg_line_status #(
         .NUM_SLOTS(NUM_SLOTS), .POP_MASK(POP_MASK)
      ) u_stat (
         .clk(clk), .rst_n(rst_n),
         .req(req_in[l*NUM_SLOTS +: NUM_SLOTS]),
         .force_bits(force_bits),
         .status_q(stat[l]),
         .line_n(irq_n[l])
      );
   end

   agg_read_port #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
      .stat0(stat[0]), .stat1(stat[1]), .force_bits(force_bits),
      .rdata(reg_rdata)
   );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [NUM_SLOTS-1:0] POP_MASK = 8'h3F
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic                   reg_rd,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]      reg_wdata,
   input logic [DATA_W-1:0]      reg_rdata,
   input logic [2*NUM_SLOTS-1:0] req_in,
   input logic [1:0]             irq_n,
   input logic [NUM_SLOTS-1:0]   force_bits
);
   logic [NUM_SLOTS-1:0] act0, act1;
   logic                 unmapped;
   assign act0 = (req_in[NUM_SLOTS-1:0] | force_bits) & POP_MASK;
   assign act1 = (req_in[2*NUM_SLOTS-1:NUM_SLOTS] | force_bits) & POP_MASK;
   assign unmapped = (reg_addr == '0) || (reg_addr > ADDR_W'(3));

   // R2: line 0 asserts after an active request
   a_r2_line0_assert: assert property (@(posedge clk) disable iff (!rst_n)
      (|act0) |=> !irq_n[0]);
   // R2: line 1 asserts after an active request
   a_r2_line1_assert: assert property (@(posedge clk) disable iff (!rst_n)
      (|act1) |=> !irq_n[1]);
   // R5: only unpopulated or no activity keeps line 0 released
   a_r5_line0_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (act0 == '0) |=> irq_n[0]);
   // R5: same for line 1
   a_r5_line1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (act1 == '0) |=> irq_n[1]);
   // R4: force register loads the populated part of the written byte
   a_r4_force_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(3)) |=>
         (force_bits == ($past(reg_wdata[NUM_SLOTS-1:0]) & POP_MASK)));
   // R6: unmapped reads return zero
   a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && unmapped) |=> (reg_rdata == '0));
   // R8: read data holds without a read strobe
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_primary_agg irq_agg_checker #(
   .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POP_MASK(POP_MASK)
) u_irq_agg_checker (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .req_in(req_in), .irq_n(irq_n), .force_bits(force_bits)
);

// File: tb/test_irq_primary_agg.sv
module test_irq_primary_agg;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] POP = 8'h3F;
   localparam int NVEC = 8;
   // {req line0, req line1, force}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h01_00_00, 24'h00_20_00, 24'h81_42_00, 24'h00_00_05,
      24'h10_01_20, 24'hC0_C0_00, 24'h00_00_C0, 24'hFF_FF_FF };

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
   logic [15:0] req_in = 0;
   logic [1:0] irq_n;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_primary_agg i_irq_primary_agg (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_in(req_in), .irq_n(irq_n));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk); reg_rd = 1; reg_addr = a;
      @(negedge clk); reg_rd = 0; d = reg_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, e0, e1;
      repeat (2) @(negedge clk);
      // R7: reset state
      chk("R7 irq_n", {6'b0, irq_n}, 8'h03);
      chk("R7 rdata", reg_rdata, 8'h00);
      rst_n = 1;
      rd(8'h01, d); chk("R7 line0 status", d, 8'h00);
      rd(8'h03, d); chk("R7 force", d, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         req_in = {VEC[i][15:8], VEC[i][23:16]};
         wr(8'h03, VEC[i][7:0]);
         @(negedge clk);
         e0 = (VEC[i][23:16] | VEC[i][7:0]) & POP;
         e1 = (VEC[i][15:8]  | VEC[i][7:0]) & POP;
         chk("R2 irq_n line0", {7'b0, irq_n[0]}, {7'b0, e0 == 0});
         chk("R2 irq_n line1", {7'b0, irq_n[1]}, {7'b0, e1 == 0});
         rd(8'h01, d); chk("R1 R3 R5 line0 status", d, e0);
         rd(8'h02, d); chk("R1 R3 R5 line1 status", d, e1);
         rd(8'h03, d); chk("R4 R5 force readback", d, VEC[i][7:0] & POP);
      end

      // R4: clearing force removes forced bits
      req_in = 0;
      wr(8'h03, 8'h00);
      @(negedge clk);
      chk("R4 force cleared irq_n", {6'b0, irq_n}, 8'h03);
      rd(8'h01, d); chk("R4 line0 after clear", d, 8'h00);

      // R1: non-sticky, request pulse for one cycle
      @(negedge clk); req_in = 16'h0004;
      @(negedge clk); req_in = 16'h0000;
      chk("R1 pulse asserts", {7'b0, irq_n[0]}, 8'h00);
      @(negedge clk);
      chk("R1 pulse releases", {7'b0, irq_n[0]}, 8'h01);

      // R6: unmapped reads and writes to status offsets
      req_in = 16'h0302;
      wr(8'h01, 8'hFF);
      wr(8'h02, 8'hFF);
      rd(8'h00, d); chk("R6 read 0x00", d, 8'h00);
      rd(8'h04, d); chk("R6 read 0x04", d, 8'h00);
      rd(8'hFF, d); chk("R6 read 0xFF", d, 8'h00);
      rd(8'h01, d); chk("R6 line0 unchanged by write", d, 8'h02);
      rd(8'h02, d); chk("R6 line1 unchanged by write", d, 8'h03);
      rd(8'h03, d); chk("R6 force unchanged", d, 8'h00);

      // R8: data holds until next read
      req_in = 16'h0000;
      rd(8'h01, d);
      repeat (3) @(negedge clk);
      chk("R8 rdata held", reg_rdata, d);

      // R5: only unpopulated slots active
      req_in = 16'hC0C0;
      repeat (2) @(negedge clk);
      chk("R5 unpopulated no irq", {6'b0, irq_n}, 8'h03);

      // R7: reset mid-operation
      wr(8'h03, 8'h11);
      rst_n = 0; @(negedge clk);
      chk("R7 reset irq_n", {6'b0, irq_n}, 8'h03);
      req_in = 0; rst_n = 1;
      rd(8'h03, d); chk("R7 force after reset", d, 8'h00);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule